// File: doc/BRIEF.md
# Dual-Width Stack Engine over a Nibble RAM

This block is the stack machinery of a 4-bit processor core. One single-port store of 256 words by 4 bits holds two stacks. The first is a 4-bit expression stack whose top element is kept in a separate accumulator register. The second is a 12-bit return stack whose entries each span three consecutive nibbles. Software places each stack, and bounds it, by loading pointer and limit registers. Two general address registers give plain data-memory reads and writes through the accumulator.

A controlling sequencer, such as an instruction decoder, drives a command port. The port carries a valid strobe, a 4-bit opcode, a nibble operand and a 12-bit operand. Expression-stack commands finish in one clock. Every return-stack command takes one clock per nibble, and the block holds `busy` high while it steps through them. Commands that move data between the two stacks first do their return-stack accesses and then their single expression access, so only one RAM access ever happens in a cycle. Any push that would carry a pointer past its limit sets a sticky overflow flag, and the push still completes.

Top module: `nibble_stack_engine`

## Requirements
- R1: After a synchronous reset, `tos`, `nos`, `ret_top`, `sp`, `rp`, `ovf` and `busy` are all zero, X and Y are zero, and both limit registers are 0xFF.
- R2: Expression push, opcode 1, is accepted when `busy` is low. In one clock it stores the old `tos` at address `sp`+1, increments `sp` and loads `cmd_nib` into `tos`.
- R3: Expression pop, opcode 2, loads `tos` from the word at address `sp` and decrements `sp`, in one clock.
- R4: Second-element read, opcode 3, copies the word at address `sp` into `nos` and changes no pointer.
- R5: Return push, opcode 4, writes the nibbles of `cmd_ret` lowest first at `rp`+1, `rp`+2 and `rp`+3. `rp` ends 3 higher, and `busy` is high for exactly the 3 cycles that follow acceptance.
- R6: Return pop, opcode 5, reads the high, middle and low nibbles from `rp`, `rp`-1 and `rp`-2. The assembled 12-bit value goes to `ret_top`, `rp` ends 3 lower, and `busy` is high for 3 cycles.
- R7: Opcode 6 pushes {8'h00, `tos`} onto the return stack and then pops the expression stack into `tos`. Opcode 7 pops the return stack into `ret_top` and then pushes its low nibble onto the expression stack. Each is busy for 4 cycles, and the return accesses come first.
- R8: Opcodes 8 to 13 load `cmd_ret[7:0]` into `sp`, `rp`, X, Y, the expression limit and the return limit, in that order.
- R9: Opcode 14 stores `tos` at address X when `cmd_nib[0]` is 0, or at address Y when it is 1. Opcode 15 loads `tos` from the same address selection.
- R10: `ovf` is set when an expression push (opcode 1 or 7) has `sp`+1 greater than the expression limit, or when a return push (opcode 4 or 6) has `rp`+3 greater than the return limit. Both compares are unsigned 9-bit sums. The push still takes place, and only reset clears `ovf`.
- R11: A command presented while `busy` is high is ignored, and opcode 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, taken only while `busy` is low |
| cmd_op | input | 4 | Opcode |
| cmd_nib | input | 4 | Nibble operand (push value or X/Y select) |
| cmd_ret | input | 12 | Return-stack operand; bits 7:0 also serve as the load value |
| busy | output | 1 | A multi-cycle command is in progress |
| tos | output | 4 | Top of the expression stack (accumulator) |
| nos | output | 4 | Last second-element read |
| ret_top | output | 12 | Value most recently popped from the return stack |
| sp | output | 8 | Expression stack pointer |
| rp | output | 8 | Return stack pointer |
| ovf | output | 1 | Sticky pointer-limit overflow |

## Verification
The assertions assume a few things about how the block is driven. The opcode is only looked at together with `cmd_valid`. Reset is asserted before the first command. Pointer steps are judged against their values in the previous cycle, so a load and a step are never expected in the same clock. The stimulus waits for `busy` to fall before it issues the next command, except in the one test that deliberately holds a command during `busy` to show it is dropped. Pointers are loaded so that the two stacks and the X/Y words never overlap, except where a pointer is deliberately driven to its limit or wrapped for the overflow cases.

// File: rtl/nstk_pkg.sv
package nstk_pkg;

    localparam int NIB_W    = 4;
    localparam int PTR_W    = 8;
    localparam int RET_NIBS = 3;
    localparam int RET_W    = NIB_W * RET_NIBS;

    typedef enum logic [3:0] {
        OP_NOP   = 4'd0,
        OP_EPUSH = 4'd1,
        OP_EPOP  = 4'd2,
        OP_ENOS  = 4'd3,
        OP_RPUSH = 4'd4,
        OP_RPOP  = 4'd5,
        OP_E2R   = 4'd6,
        OP_R2E   = 4'd7,
        OP_LDSP  = 4'd8,
        OP_LDRP  = 4'd9,
        OP_LDX   = 4'd10,
        OP_LDY   = 4'd11,
        OP_LIME  = 4'd12,
        OP_LIMR  = 4'd13,
        OP_MWR   = 4'd14,
        OP_MRD   = 4'd15
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RET,
        ST_EXP
    } seq_st_e;

    typedef enum logic [1:0] {
        PA_HOLD,
        PA_INC,
        PA_DEC,
        PA_LOAD
    } ptr_act_e;

    typedef struct packed {
        ptr_act_e sp_act;
        ptr_act_e rp_act;
        logic     x_ld;
        logic     y_ld;
        logic     elim_ld;
        logic     rlim_ld;
        logic     e_chk;
        logic     r_chk;
    } ptr_ctl_t;

    // Return-stack command that writes nibbles (as opposed to reading them)
    function automatic logic ret_is_write(op_e op);
        return (op == OP_RPUSH) || (op == OP_E2R);
    endfunction

    // Command that touches both stacks
    function automatic logic ret_is_xfer(op_e op);
        return (op == OP_E2R) || (op == OP_R2E);
    endfunction

endpackage

// File: rtl/nstk_ram.sv
module nstk_ram #(
    parameter int NIB_W = nstk_pkg::NIB_W,
    parameter int PTR_W = nstk_pkg::PTR_W
) (
    input  logic             clk,
    input  logic             we,
    input  logic [PTR_W-1:0] addr,
    input  logic [NIB_W-1:0] wdata,
    output logic [NIB_W-1:0] rdata
);
    localparam int DEPTH = 1 << PTR_W;

    logic [NIB_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/nstk_ptr_file.sv
module nstk_ptr_file
    import nstk_pkg::*;
#(
    parameter int PTR_W    = nstk_pkg::PTR_W,
    parameter int RET_NIBS = nstk_pkg::RET_NIBS
) (
    input  logic             clk,
    input  logic             rst,
    input  ptr_ctl_t         ctl,
    input  logic [PTR_W-1:0] ld_val,
    output logic [PTR_W-1:0] sp,
    output logic [PTR_W-1:0] rp,
    output logic [PTR_W-1:0] x_ptr,
    output logic [PTR_W-1:0] y_ptr,
    output logic             ovf
);
    localparam logic [PTR_W:0] RET_SPAN = (PTR_W+1)'(RET_NIBS);
    localparam logic [PTR_W:0] ONE_W    = (PTR_W+1)'(1);

    logic [PTR_W-1:0] elim_q, rlim_q;
    logic             e_hit, r_hit;

    function automatic logic [PTR_W-1:0] step_ptr(
        input logic [PTR_W-1:0] cur,
        input ptr_act_e         act,
        input logic [PTR_W-1:0] val
    );
        case (act)
            PA_INC:  return cur + 1'b1;
            PA_DEC:  return cur - 1'b1;
            PA_LOAD: return val;
            default: return cur;
        endcase
    endfunction

    assign e_hit = ctl.e_chk && (({1'b0, sp} + ONE_W)    > {1'b0, elim_q});
    assign r_hit = ctl.r_chk && (({1'b0, rp} + RET_SPAN) > {1'b0, rlim_q});

    always_ff @(posedge clk) begin
        if (rst) begin
            sp     <= '0;
            rp     <= '0;
            x_ptr  <= '0;
            y_ptr  <= '0;
            elim_q <= '1;
            rlim_q <= '1;
            ovf    <= 1'b0;
        end else begin
            sp <= step_ptr(sp, ctl.sp_act, ld_val);
            rp <= step_ptr(rp, ctl.rp_act, ld_val);
            if (ctl.x_ld)    x_ptr  <= ld_val;
            if (ctl.y_ld)    y_ptr  <= ld_val;
            if (ctl.elim_ld) elim_q <= ld_val;
            if (ctl.rlim_ld) rlim_q <= ld_val;
            if (e_hit || r_hit) ovf <= 1'b1;
        end
    end

    // R10
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf);

    // R10
    ovf_raise_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.e_chk && (sp == elim_q)) |=> ovf);

endmodule

// File: rtl/nstk_seq.sv
module nstk_seq
    import nstk_pkg::*;
#(
    parameter int NIB_W    = nstk_pkg::NIB_W,
    parameter int PTR_W    = nstk_pkg::PTR_W,
    parameter int RET_NIBS = nstk_pkg::RET_NIBS
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cmd_valid,
    input  logic [3:0]                cmd_op,
    input  logic [NIB_W-1:0]          cmd_nib,
    input  logic [NIB_W*RET_NIBS-1:0] cmd_ret,
    input  logic [PTR_W-1:0]          sp,
    input  logic [PTR_W-1:0]          rp,
    input  logic [PTR_W-1:0]          x_ptr,
    input  logic [PTR_W-1:0]          y_ptr,
    input  logic [NIB_W-1:0]          ram_rdata,
    output logic                      ram_we,
    output logic [PTR_W-1:0]          ram_addr,
    output logic [NIB_W-1:0]          ram_wdata,
    output ptr_ctl_t                  ctl,
    output logic                      busy,
    output logic [NIB_W-1:0]          tos,
    output logic [NIB_W-1:0]          nos,
    output logic [NIB_W*RET_NIBS-1:0] ret_top
);
    localparam int RW       = NIB_W * RET_NIBS;
    localparam int STEP_W   = $clog2(RET_NIBS + 1);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(RET_NIBS - 1);

    seq_st_e          state_q;
    op_e              cur_op_q;
    op_e              op_in;
    logic [STEP_W-1:0] step_q;
    logic [RW-1:0]    ret_buf_q;
    logic [RW-1:0]    ret_asm;
    logic             ret_wr;
    logic             accept;
    logic [PTR_W-1:0] xy_addr;
    int               rd_idx;
    int               wr_idx;

    assign op_in   = op_e'(cmd_op);
    assign accept  = (state_q == ST_IDLE) && cmd_valid;
    assign busy    = (state_q != ST_IDLE);
    assign ret_wr  = ret_is_write(cur_op_q);
    assign xy_addr = cmd_nib[0] ? y_ptr : x_ptr;
    assign rd_idx  = RET_NIBS - 1 - int'(step_q);
    assign wr_idx  = int'(step_q);
    assign ret_asm = {ret_buf_q[RW-1:NIB_W], ram_rdata};

    // One RAM access per cycle; return-stack steps own the port while busy
    always_comb begin
        ram_we    = 1'b0;
        ram_addr  = sp;
        ram_wdata = tos;
        ctl       = '{sp_act: PA_HOLD, rp_act: PA_HOLD, default: 1'b0};
        case (state_q)
            ST_IDLE: begin
                if (cmd_valid) begin
                    case (op_in)
                        OP_EPUSH: begin
                            ram_we     = 1'b1;
                            ram_addr   = sp + 1'b1;
                            ctl.sp_act = PA_INC;
                            ctl.e_chk  = 1'b1;
                        end
                        OP_EPOP:  ctl.sp_act  = PA_DEC;
                        OP_RPUSH,
                        OP_E2R:   ctl.r_chk   = 1'b1;
                        OP_LDSP:  ctl.sp_act  = PA_LOAD;
                        OP_LDRP:  ctl.rp_act  = PA_LOAD;
                        OP_LDX:   ctl.x_ld    = 1'b1;
                        OP_LDY:   ctl.y_ld    = 1'b1;
                        OP_LIME:  ctl.elim_ld = 1'b1;
                        OP_LIMR:  ctl.rlim_ld = 1'b1;
                        OP_MWR: begin
                            ram_we   = 1'b1;
                            ram_addr = xy_addr;
                        end
                        OP_MRD:   ram_addr = xy_addr;
                        default: ;
                    endcase
                end
            end
            ST_RET: begin
                if (ret_wr) begin
                    ram_we     = 1'b1;
                    ram_addr   = rp + 1'b1;
                    ram_wdata  = ret_buf_q[wr_idx*NIB_W +: NIB_W];
                    ctl.rp_act = PA_INC;
                end else begin
                    ram_addr   = rp;
                    ctl.rp_act = PA_DEC;
                end
            end
            ST_EXP: begin
                if (cur_op_q == OP_E2R) begin
                    ctl.sp_act = PA_DEC;
                end else begin
                    ram_we     = 1'b1;
                    ram_addr   = sp + 1'b1;
                    ctl.sp_act = PA_INC;
                    ctl.e_chk  = 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            cur_op_q  <= OP_NOP;
            step_q    <= '0;
            ret_buf_q <= '0;
            tos       <= '0;
            nos       <= '0;
            ret_top   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        case (op_in)
                            OP_EPUSH: tos <= cmd_nib;
                            OP_EPOP,
                            OP_MRD:   tos <= ram_rdata;
                            OP_ENOS:  nos <= ram_rdata;
                            OP_RPUSH,
                            OP_RPOP,
                            OP_E2R,
                            OP_R2E: begin
                                if (op_in == OP_RPUSH) ret_buf_q <= cmd_ret;
                                if (op_in == OP_E2R)   ret_buf_q <= RW'(tos);
                                cur_op_q <= op_in;
                                step_q   <= '0;
                                state_q  <= ST_RET;
                            end
                            default: ;
                        endcase
                    end
                end
                ST_RET: begin
                    if (!ret_wr) begin
                        ret_buf_q[rd_idx*NIB_W +: NIB_W] <= ram_rdata;
                    end
                    step_q <= step_q + 1'b1;
                    if (step_q == LAST_STEP) begin
                        if (!ret_wr) ret_top <= ret_asm;
                        state_q <= ret_is_xfer(cur_op_q) ? ST_EXP : ST_IDLE;
                    end
                end
                ST_EXP: begin
                    tos     <= (cur_op_q == OP_E2R) ? ram_rdata : ret_buf_q[NIB_W-1:0];
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R2
    epush_sp_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && op_in == OP_EPUSH) |=> (sp == PTR_W'($past(sp) + 1'b1)));

    // R3
    epop_sp_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && op_in == OP_EPOP) |=> (sp == PTR_W'($past(sp) - 1'b1)));

    // R5
    ret_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && (op_in == OP_RPUSH || op_in == OP_RPOP)) |=> busy);

    // R6
    rpop_step_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RET && !ret_wr) |=> (rp == PTR_W'($past(rp) - 1'b1)));

    // R11
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && state_q == ST_RET && step_q != LAST_STEP) |=> $stable(sp));

endmodule

// File: rtl/nibble_stack_engine.sv
module nibble_stack_engine
    import nstk_pkg::*;
#(
    parameter int NIB_W    = nstk_pkg::NIB_W,
    parameter int PTR_W    = nstk_pkg::PTR_W,
    parameter int RET_NIBS = nstk_pkg::RET_NIBS
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cmd_valid,
    input  logic [3:0]                cmd_op,
    input  logic [NIB_W-1:0]          cmd_nib,
    input  logic [NIB_W*RET_NIBS-1:0] cmd_ret,
    output logic                      busy,
    output logic [NIB_W-1:0]          tos,
    output logic [NIB_W-1:0]          nos,
    output logic [NIB_W*RET_NIBS-1:0] ret_top,
    output logic [PTR_W-1:0]          sp,
    output logic [PTR_W-1:0]          rp,
    output logic                      ovf
);
    logic             ram_we;
    logic [PTR_W-1:0] ram_addr;
    logic [NIB_W-1:0] ram_wdata;
    logic [NIB_W-1:0] ram_rdata;
    logic [PTR_W-1:0] x_ptr, y_ptr;
    ptr_ctl_t         ctl;

    nstk_seq #(
        .NIB_W(NIB_W), .PTR_W(PTR_W), .RET_NIBS(RET_NIBS)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_nib   (cmd_nib),
        .cmd_ret   (cmd_ret),
        .sp        (sp),
        .rp        (rp),
        .x_ptr     (x_ptr),
        .y_ptr     (y_ptr),
        .ram_rdata (ram_rdata),
        .ram_we    (ram_we),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata),
        .ctl       (ctl),
        .busy      (busy),
        .tos       (tos),
        .nos       (nos),
        .ret_top   (ret_top)
    );

    nstk_ptr_file #(
        .PTR_W(PTR_W), .RET_NIBS(RET_NIBS)
    ) u_ptrs (
        .clk    (clk),
        .rst    (rst),
        .ctl    (ctl),
        .ld_val (cmd_ret[PTR_W-1:0]),
        .sp     (sp),
        .rp     (rp),
        .x_ptr  (x_ptr),
        .y_ptr  (y_ptr),
        .ovf    (ovf)
    );

    nstk_ram #(
        .NIB_W(NIB_W), .PTR_W(PTR_W)
    ) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (ram_wdata),
        .rdata (ram_rdata)
    );

endmodule

// File: tb/nibble_stack_engine_bench.sv
module nibble_stack_engine_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [3:0]  cmd_op = 4'd0;
    logic [3:0]  cmd_nib = 4'd0;
    logic [11:0] cmd_ret = 12'd0;
    logic        busy;
    logic [3:0]  tos, nos;
    logic [11:0] ret_top;
    logic [7:0]  sp, rp;
    logic        ovf;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    nibble_stack_engine u_nibble_stack_engine (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_nib(cmd_nib), .cmd_ret(cmd_ret), .busy(busy), .tos(tos),
        .nos(nos), .ret_top(ret_top), .sp(sp), .rp(rp), .ovf(ovf)
    );

    // req, op, nib, ret, exp tos, exp nos, exp ret_top, exp sp, exp rp
    typedef struct packed {
        logic [3:0]  req;
        logic [3:0]  op;
        logic [3:0]  nib;
        logic [11:0] ret;
        logic [3:0]  e_tos;
        logic [3:0]  e_nos;
        logic [11:0] e_ret;
        logic [7:0]  e_sp;
        logic [7:0]  e_rp;
    } vec_t;

    localparam int NV = 23;
    localparam logic [59:0] VEC [NV] = '{
        {4'd8,  4'h8, 4'h0, 12'h010, 4'h0, 4'h0, 12'h000, 8'h10, 8'h00}, // R8 load sp
        {4'd8,  4'h9, 4'h0, 12'h080, 4'h0, 4'h0, 12'h000, 8'h10, 8'h80}, // R8 load rp
        {4'd2,  4'h1, 4'h5, 12'h000, 4'h5, 4'h0, 12'h000, 8'h11, 8'h80}, // R2
        {4'd2,  4'h1, 4'hA, 12'h000, 4'hA, 4'h0, 12'h000, 8'h12, 8'h80}, // R2
        {4'd2,  4'h1, 4'h3, 12'h000, 4'h3, 4'h0, 12'h000, 8'h13, 8'h80}, // R2
        {4'd4,  4'h3, 4'h0, 12'h000, 4'h3, 4'hA, 12'h000, 8'h13, 8'h80}, // R4
        {4'd3,  4'h2, 4'h0, 12'h000, 4'hA, 4'hA, 12'h000, 8'h12, 8'h80}, // R3
        {4'd4,  4'h3, 4'h0, 12'h000, 4'hA, 4'h5, 12'h000, 8'h12, 8'h80}, // R4
        {4'd5,  4'h4, 4'h0, 12'hBCD, 4'hA, 4'h5, 12'h000, 8'h12, 8'h83}, // R5
        {4'd5,  4'h4, 4'h0, 12'h123, 4'hA, 4'h5, 12'h000, 8'h12, 8'h86}, // R5
        {4'd6,  4'h5, 4'h0, 12'h000, 4'hA, 4'h5, 12'h123, 8'h12, 8'h83}, // R6
        {4'd7,  4'h6, 4'h0, 12'h000, 4'h5, 4'h5, 12'h123, 8'h11, 8'h86}, // R7 exp->ret
        {4'd7,  4'h7, 4'h0, 12'h000, 4'hA, 4'h5, 12'h00A, 8'h12, 8'h83}, // R7 ret->exp
        {4'd4,  4'h3, 4'h0, 12'h000, 4'hA, 4'h5, 12'h00A, 8'h12, 8'h83}, // R4
        {4'd6,  4'h5, 4'h0, 12'h000, 4'hA, 4'h5, 12'hBCD, 8'h12, 8'h80}, // R6
        {4'd8,  4'hA, 4'h0, 12'h040, 4'hA, 4'h5, 12'hBCD, 8'h12, 8'h80}, // R8 load X
        {4'd9,  4'hE, 4'h0, 12'h000, 4'hA, 4'h5, 12'hBCD, 8'h12, 8'h80}, // R9 store via X
        {4'd8,  4'hB, 4'h0, 12'h041, 4'hA, 4'h5, 12'hBCD, 8'h12, 8'h80}, // R8 load Y
        {4'd2,  4'h1, 4'h7, 12'h000, 4'h7, 4'h5, 12'hBCD, 8'h13, 8'h80}, // R2
        {4'd9,  4'hE, 4'h1, 12'h000, 4'h7, 4'h5, 12'hBCD, 8'h13, 8'h80}, // R9 store via Y
        {4'd9,  4'hF, 4'h0, 12'h000, 4'hA, 4'h5, 12'hBCD, 8'h13, 8'h80}, // R9 load via X
        {4'd9,  4'hF, 4'h1, 12'h000, 4'h7, 4'h5, 12'hBCD, 8'h13, 8'h80}, // R9 load via Y
        {4'd3,  4'h2, 4'h0, 12'h000, 4'hA, 4'h5, 12'hBCD, 8'h12, 8'h80}  // R3
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        cmd_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // Issue one command and wait at a falling edge until it has completed
    task automatic issue(input logic [3:0] op, input logic [3:0] nib, input logic [11:0] ret);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_nib   = nib;
        cmd_ret   = ret;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (busy) @(negedge clk);
    endtask

    // Issue a command and return how many cycles busy stayed high
    task automatic busy_len(input logic [3:0] op, input logic [11:0] ret, output int cnt);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_nib   = 4'h0;
        cmd_ret   = ret;
        @(negedge clk);
        cmd_valid = 1'b0;
        cnt = 0;
        while (busy && cnt < 20) begin
            cnt++;
            @(negedge clk);
        end
    endtask

    initial begin
        int cnt;
        do_reset();
        @(negedge clk);

        // R1 reset state
        chk("R1 tos", 32'(tos), 32'h0);
        chk("R1 nos", 32'(nos), 32'h0);
        chk("R1 ret_top", 32'(ret_top), 32'h0);
        chk("R1 sp", 32'(sp), 32'h0);
        chk("R1 rp", 32'(rp), 32'h0);
        chk("R1 ovf", 32'(ovf), 32'h0);
        chk("R1 busy", 32'(busy), 32'h0);

        // Vector walk
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            string tag;
            v = vec_t'(VEC[i]);
            issue(v.op, v.nib, v.ret);
            tag = $sformatf("R%0d vec%0d", v.req, i);
            chk({tag, " tos"}, 32'(tos), 32'(v.e_tos));
            chk({tag, " nos"}, 32'(nos), 32'(v.e_nos));
            chk({tag, " ret_top"}, 32'(ret_top), 32'(v.e_ret));
            chk({tag, " sp"}, 32'(sp), 32'(v.e_sp));
            chk({tag, " rp"}, 32'(rp), 32'(v.e_rp));
            chk({tag, " ovf"}, 32'(ovf), 32'h0);
        end

        // R5 / R6 / R7 busy lengths
        busy_len(4'h4, 12'h321, cnt);
        chk("R5 busy cycles", 32'(cnt), 32'd3);
        busy_len(4'h5, 12'h000, cnt);
        chk("R6 busy cycles", 32'(cnt), 32'd3);
        chk("R6 popped value", 32'(ret_top), 32'h321);
        busy_len(4'h6, 12'h000, cnt);
        chk("R7 exp->ret busy cycles", 32'(cnt), 32'd4);
        busy_len(4'h7, 12'h000, cnt);
        chk("R7 ret->exp busy cycles", 32'(cnt), 32'd4);

        // R11: command held during busy is dropped; NOP has no effect
        do_reset();
        issue(4'h8, 4'h0, 12'h020);
        issue(4'h1, 4'h6, 12'h000);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op = 4'h4; cmd_nib = 4'h0; cmd_ret = 12'h777;
        @(negedge clk);
        cmd_op = 4'h1; cmd_nib = 4'h9;
        while (busy) @(negedge clk);
        cmd_valid = 1'b0;
        chk("R11 sp unchanged while busy", 32'(sp), 32'h21);
        chk("R11 tos unchanged while busy", 32'(tos), 32'h6);
        chk("R11 rp after push", 32'(rp), 32'h03);
        issue(4'h0, 4'hF, 12'hFFF);
        chk("R11 nop sp", 32'(sp), 32'h21);
        chk("R11 nop rp", 32'(rp), 32'h03);
        chk("R11 nop tos", 32'(tos), 32'h6);
        issue(4'h5, 4'h0, 12'h000);
        chk("R11 return value intact", 32'(ret_top), 32'h777);

        // R10 expression overflow against reset limit 0xFF, with wrap
        do_reset();
        issue(4'h8, 4'h0, 12'h0FE);
        issue(4'h1, 4'h1, 12'h000);
        chk("R10 push to limit no ovf", 32'(ovf), 32'h0);
        chk("R10 sp at limit", 32'(sp), 32'hFF);
        issue(4'h1, 4'h2, 12'h000);
        chk("R10 push past limit ovf", 32'(ovf), 32'h1);
        chk("R10 sp wrapped", 32'(sp), 32'h00);
        chk("R10 push still done", 32'(tos), 32'h2);
        issue(4'h2, 4'h0, 12'h000);
        chk("R10 ovf sticky", 32'(ovf), 32'h1);

        // R10 return overflow with loaded limit
        do_reset();
        issue(4'hD, 4'h0, 12'h010);
        issue(4'h9, 4'h0, 12'h00D);
        issue(4'h4, 4'h0, 12'hABC);
        chk("R10 ret push to limit no ovf", 32'(ovf), 32'h0);
        chk("R10 rp at limit", 32'(rp), 32'h10);
        issue(4'h4, 4'h0, 12'hDEF);
        chk("R10 ret push past limit ovf", 32'(ovf), 32'h1);
        chk("R10 rp advanced", 32'(rp), 32'h13);

        // R10 loaded expression limit
        do_reset();
        issue(4'hC, 4'h0, 12'h005);
        issue(4'h8, 4'h0, 12'h004);
        issue(4'h1, 4'h3, 12'h000);
        chk("R10 elim reached no ovf", 32'(ovf), 32'h0);
        issue(4'h1, 4'h4, 12'h000);
        chk("R10 elim passed ovf", 32'(ovf), 32'h1);
        do_reset();
        @(negedge clk);
        chk("R1 reset clears ovf", 32'(ovf), 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule